// File: doc/BRIEF.md
# SD Command Response Receiver

This block listens on the SD command line once the host has sent a command. It waits for the card to drive a start bit and then shifts the response in, one bit per SD clock, until it has a 48-bit short frame or a 136-bit long frame. The frame length follows the 3-bit response-type code that is programmed with the command. The SD clock reaches the block as a one-cycle strobe, `sd_tick_i`, in the system clock domain. The line is sampled on every clock edge where that strobe is high.

At the end of a frame the payload goes into four 32-bit read registers and the frame is checked. The checks cover the end bit, the command index (or the all-ones field that some responses carry in its place) and the CRC7 where it applies. The result appears as one-cycle status pulses: completion, response timeout, end-bit error, CRC error and index error. For the busy response type, a busy flag follows DAT0 once the response has arrived. The response arrives as a bit stream with no back-pressure, so the block has no handshake. Every port is a plain control, status or data pin.

Top module: `sd_rsp_rx`

## Requirements
- R1: A start pulse with type code 3 (no response) or any code below 4 raises `done_o` for one cycle on the clock after the start pulse. No frame is awaited and the response registers keep their values.
- R2: For type codes 4, 5 and 7 a 48-bit frame is received, first bit = frame bit 47. `rsp_w0_o` receives frame bits [39:8] and `rsp_w1_o`..`rsp_w3_o` are cleared.
- R3: For type code 6 a 136-bit frame is received. `rsp_w0_o`..`rsp_w2_o` receive frame bits [39:8], [71:40] and [103:72]. `rsp_w3_o` receives bits [127:104] in its low 24 bits, with zeros above.
- R4: After a start pulse that expects a frame, each SD tick with the line high counts toward `TIMEOUT` (64). If the line is still high on the `TIMEOUT`-th such tick, `err_rto_o` pulses instead of `done_o` and the block returns to idle. A start bit on the `TIMEOUT`-th tick is still accepted.
- R5: A frame whose last bit (bit 0) is 0 raises `err_end_o`.
- R6: For type codes 4 and 5, frame bits [7:1] must equal the CRC7 of frame bits [47:8], computed MSB first with polynomial x^7+x^3+1 from a zero seed. A mismatch raises `err_crc_o`. For codes 6 and 7 the CRC is not checked.
- R7: For type codes 4 and 5, frame bits [45:40] must equal `cmd_idx_i` as latched at the start pulse. For code 7, bits [45:40] must be all ones. For code 6, bits [133:128] must be all ones. A mismatch raises `err_idx_o`.
- R8: All end-of-frame status pulses last one clock and appear on the clock after the tick that sampled the last bit. `done_o` pulses only when no error flag does. The registers are loaded at the end of every frame, even one that has errors.
- R9: After an error-free frame of type code 5, `busy_o` rises together with `done_o`. It stays high until an SD tick samples `dat0_i` high, and falls on the following clock.
- R10: A start pulse while a frame is awaited, being received, or while `busy_o` is high is ignored.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_tick_i | input | 1 | One-cycle strobe marking an SD clock sampling point |
| cmd_start_i | input | 1 | Pulse at the end of command transmission |
| rsp_type_i | input | 3 | Response-type code, sampled with `cmd_start_i` |
| cmd_idx_i | input | 6 | Index of the issued command, sampled with `cmd_start_i` |
| cmd_line_i | input | 1 | Serial SD command line |
| dat0_i | input | 1 | SD DAT0 line, used for busy signalling |
| rsp_w0_o | output | 32 | Response register 0 |
| rsp_w1_o | output | 32 | Response register 1 |
| rsp_w2_o | output | 32 | Response register 2 |
| rsp_w3_o | output | 32 | Response register 3 (24 valid bits) |
| done_o | output | 1 | Response-complete pulse |
| err_rto_o | output | 1 | Response-timeout pulse |
| err_end_o | output | 1 | End-bit error pulse |
| err_crc_o | output | 1 | CRC7 error pulse |
| err_idx_o | output | 1 | Index-field error pulse |
| busy_o | output | 1 | Card busy after a busy-type response |
| active_o | output | 1 | A response is awaited or being received |

## Verification
On every cycle, the assertions check the following:
- completion never coincides with an error;
- a timeout only follows an active wait;
- busy starts only with a completion and ends on the first tick that samples DAT0 high;
- busy and reception are never both active;
- the response registers change only when an end-of-frame pulse fires;
- the top register's padding stays zero.

Only the bench scenarios can show the payload mapping, the CRC7 value and the index comparison for each type code. The same holds for the exact tick on which the timeout expires and for a start pulse being ignored during busy. The bench shows these by sweeping type codes, command indices, payloads, start-bit delays and injected faults.

// File: rtl/sd_rsp_pkg.sv
package sd_rsp_pkg;
  localparam int SHORT_LEN = 48;
  localparam int LONG_LEN  = 136;
  localparam int CRC_SPAN  = 40;
  localparam int CRC_W     = 7;
  localparam int IDX_W     = 6;
  localparam int REG_W     = 32;
  localparam int NREG      = 4;
  localparam int PAY_LO    = 8;
  localparam int PAY_W     = LONG_LEN - 8 - PAY_LO;  // 120 stored bits
  localparam int SR_W      = LONG_LEN - 2;           // start/tx bits of long frame not kept

  localparam logic [2:0] RT_NONE = 3'd3;
  localparam logic [2:0] RT_R1   = 3'd4;
  localparam logic [2:0] RT_R1B  = 3'd5;
  localparam logic [2:0] RT_R2   = 3'd6;
  localparam logic [2:0] RT_R3   = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RECV, ST_BUSY} rx_state_e;

  typedef struct packed {
    logic endb;
    logic crc;
    logic idx;
  } frame_err_t;
endpackage

// File: rtl/sd_rsp_crc7.sv
module sd_rsp_crc7 #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic         fb;
  logic [W-1:0] crc_nxt;

  assign fb      = bit_i ^ crc_o[W-1];
  assign crc_nxt = {crc_o[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_o <= '0;
    else if (clr) crc_o <= '0;
    else if (en)  crc_o <= crc_nxt;
  end
endmodule

// File: rtl/sd_rsp_shift.sv
module sd_rsp_shift #(
  parameter int W = 134
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-2:0] sr;

  // newest bit at position 0; nxt_o is the window including the bit being sampled
  assign nxt_o = {sr, bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr <= '0;
    else if (en) sr <= nxt_o[W-2:0];
  end
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store #(
  parameter int REG_W = 32,
  parameter int NREG  = 4,
  parameter int PAY_W = 120
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  long_i,
  input  logic [PAY_W-1:0]      pay_i,
  output logic [NREG*REG_W-1:0] regs_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam int LO = k * REG_W;
    localparam int VB = (PAY_W - LO >= REG_W) ? REG_W : PAY_W - LO;
    logic [REG_W-1:0] r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else if (load) begin
        if (long_i || k == 0) r <= REG_W'(pay_i[LO +: VB]);
        else                  r <= '0;
      end
    end

    assign regs_o[LO +: REG_W] = r;
  end
endmodule

// File: rtl/sd_rsp_rx.sv
module sd_rsp_rx
  import sd_rsp_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd_tick_i,
  input  logic             cmd_start_i,
  input  logic [2:0]       rsp_type_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic             cmd_line_i,
  input  logic             dat0_i,
  output logic [REG_W-1:0] rsp_w0_o,
  output logic [REG_W-1:0] rsp_w1_o,
  output logic [REG_W-1:0] rsp_w2_o,
  output logic [REG_W-1:0] rsp_w3_o,
  output logic             done_o,
  output logic             err_rto_o,
  output logic             err_end_o,
  output logic             err_crc_o,
  output logic             err_idx_o,
  output logic             busy_o,
  output logic             active_o
);
  localparam int BCW = $clog2(LONG_LEN + 1);
  localparam int TCW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [BCW-1:0] SHORT_LAST = BCW'(SHORT_LEN - 1);
  localparam logic [BCW-1:0] LONG_LAST  = BCW'(LONG_LEN - 1);
  localparam logic [BCW-1:0] CRC_LIM    = BCW'(CRC_SPAN);
  localparam logic [TCW-1:0] TO_LAST    = TCW'(TIMEOUT - 1);

  rx_state_e        state;
  logic [2:0]       type_q;
  logic [IDX_W-1:0] idx_q;
  logic [TCW-1:0]   tcnt;
  logic [BCW-1:0]   bcnt;

  logic             is_long, shift_en, crc_en, crc_clr, last_bit;
  logic [BCW-1:0]   last_idx;
  logic [SR_W-1:0]  frame;
  logic [CRC_W-1:0] crc;
  logic [IDX_W-1:0] idx_field, idx_exp;
  frame_err_t       ferr;
  logic [NREG*REG_W-1:0] regs;

  assign is_long  = (type_q == RT_R2);
  assign last_idx = is_long ? LONG_LAST : SHORT_LAST;
  assign shift_en = sd_tick_i && ((state == ST_WAIT && !cmd_line_i) || state == ST_RECV);
  assign crc_en   = shift_en && (bcnt < CRC_LIM);
  assign crc_clr  = (state == ST_IDLE) && cmd_start_i;
  assign last_bit = sd_tick_i && (state == ST_RECV) && (bcnt == last_idx);

  sd_rsp_shift #(.W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(shift_en), .bit_i(cmd_line_i), .nxt_o(frame)
  );

  sd_rsp_crc7 #(.W(CRC_W), .POLY(7'h09)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .bit_i(cmd_line_i), .crc_o(crc)
  );

  sd_rsp_store #(.REG_W(REG_W), .NREG(NREG), .PAY_W(PAY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(last_bit), .long_i(is_long),
    .pay_i(frame[PAY_LO +: PAY_W]), .regs_o(regs)
  );

  assign rsp_w0_o = regs[0*REG_W +: REG_W];
  assign rsp_w1_o = regs[1*REG_W +: REG_W];
  assign rsp_w2_o = regs[2*REG_W +: REG_W];
  assign rsp_w3_o = regs[3*REG_W +: REG_W];

  // frame checks, evaluated on the window that includes the bit now sampled
  assign idx_field = is_long ? frame[LONG_LEN-3 -: IDX_W] : frame[SHORT_LEN-3 -: IDX_W];
  assign idx_exp   = (type_q == RT_R2 || type_q == RT_R3) ? '1 : idx_q;
  assign ferr.endb = !frame[0];
  assign ferr.crc  = (type_q == RT_R1 || type_q == RT_R1B) && (frame[CRC_W:1] != crc);
  assign ferr.idx  = (idx_field != idx_exp);

  assign active_o = (state == ST_WAIT) || (state == ST_RECV);
  assign busy_o   = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      type_q    <= '0;
      idx_q     <= '0;
      tcnt      <= '0;
      bcnt      <= '0;
      done_o    <= 1'b0;
      err_rto_o <= 1'b0;
      err_end_o <= 1'b0;
      err_crc_o <= 1'b0;
      err_idx_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      err_rto_o <= 1'b0;
      err_end_o <= 1'b0;
      err_crc_o <= 1'b0;
      err_idx_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_start_i) begin
          type_q <= rsp_type_i;
          idx_q  <= cmd_idx_i;
          tcnt   <= '0;
          bcnt   <= '0;
          if (rsp_type_i >= RT_R1) state <= ST_WAIT;
          else                     done_o <= 1'b1;
        end
        ST_WAIT: if (sd_tick_i) begin
          if (!cmd_line_i) begin
            bcnt  <= BCW'(1);
            state <= ST_RECV;
          end else if (tcnt == TO_LAST) begin
            err_rto_o <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RECV: if (sd_tick_i) begin
          if (bcnt == last_idx) begin
            err_end_o <= ferr.endb;
            err_crc_o <= ferr.crc;
            err_idx_o <= ferr.idx;
            done_o    <= (ferr == '0);
            state     <= (type_q == RT_R1B && ferr == '0) ? ST_BUSY : ST_IDLE;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_BUSY: if (sd_tick_i && dat0_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_rsp_rx_chk.sv
module sd_rsp_rx_chk #(
  parameter int REG_W = 32,
  parameter int PAD_LO = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_tick_i,
  input logic             dat0_i,
  input logic [REG_W-1:0] rsp_w0_o,
  input logic [REG_W-1:0] rsp_w3_o,
  input logic             done_o,
  input logic             err_rto_o,
  input logic             err_end_o,
  input logic             err_crc_o,
  input logic             err_idx_o,
  input logic             busy_o,
  input logic             active_o
);
  logic frame_end;
  assign frame_end = done_o || err_end_o || err_crc_o || err_idx_o;

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(err_rto_o || err_end_o || err_crc_o || err_idx_o));

  // R4
  rto_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rto_o |-> $past(active_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> done_o);

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sd_tick_i && dat0_i) |=> !busy_o);

  // R10
  busy_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !active_o);

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |-> $stable(rsp_w0_o));

  // R3
  top_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_w3_o[REG_W-1:PAD_LO] == '0);
endmodule

bind sd_rsp_rx sd_rsp_rx_chk #(.REG_W(32), .PAD_LO(24)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_tick_i(sd_tick_i), .dat0_i(dat0_i),
  .rsp_w0_o(rsp_w0_o), .rsp_w3_o(rsp_w3_o), .done_o(done_o),
  .err_rto_o(err_rto_o), .err_end_o(err_end_o), .err_crc_o(err_crc_o),
  .err_idx_o(err_idx_o), .busy_o(busy_o), .active_o(active_o)
);

// File: tb/tb_sd_rsp_rx.sv
module tb_sd_rsp_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, cmd = 1'b1, dat0 = 1'b1;
  logic [2:0] rtype = '0;
  logic [5:0] cidx = '0;
  logic [31:0] w0, w1, w2, w3;
  logic done, rto, eend, ecrc, eidx, busy, active;
  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  sd_rsp_rx #(.TIMEOUT(64)) dut (
    .clk(clk), .rst_n(rst_n), .sd_tick_i(tick), .cmd_start_i(start),
    .rsp_type_i(rtype), .cmd_idx_i(cidx), .cmd_line_i(cmd), .dat0_i(dat0),
    .rsp_w0_o(w0), .rsp_w1_o(w1), .rsp_w2_o(w2), .rsp_w3_o(w3),
    .done_o(done), .err_rto_o(rto), .err_end_o(eend), .err_crc_o(ecrc),
    .err_idx_o(eidx), .busy_o(busy), .active_o(active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // status packed as {done, rto, end, crc, idx}
  function automatic logic [31:0] stat();
    return {27'd0, done, rto, eend, ecrc, eidx};
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); cmd = b; tick = 1'b1;
    @(negedge clk); tick = 1'b0; cmd = 1'b1;
  endtask

  task automatic issue(input logic [2:0] t, input logic [5:0] i);
    @(negedge clk); start = 1'b1; rtype = t; cidx = i;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic short_case(input string tag, input logic [2:0] t, input logic [5:0] iss,
                            input logic [5:0] rxi, input logic [31:0] pay,
                            input logic [6:0] flip, input logic endb, input int h);
    logic [47:0] f;
    logic e_end, e_crc, e_idx;
    f = {2'b00, rxi, pay, 8'h00};
    f[7:1] = crc7(f[47:8]) ^ flip;
    f[0] = endb;
    issue(t, iss);
    for (int k = 0; k < h; k++) send_bit(1'b1);
    for (int k = 47; k >= 0; k--) send_bit(f[k]);
    e_end = !endb;
    e_crc = (t == 3'd4 || t == 3'd5) && (flip != 0);
    e_idx = (t == 3'd7) ? (rxi != 6'h3F) : (rxi != iss);
    chk({tag, " R8 status"}, stat(), {27'd0, !(e_end | e_crc | e_idx), 1'b0, e_end, e_crc, e_idx});
    chk({tag, " R2 w0"}, w0, pay);
    chk({tag, " R2 w1..w3"}, w1 | w2 | w3, 32'd0);
    send_bit(1'b1);
  endtask

  task automatic long_case(input string tag, input logic [127:0] pat, input logic [5:0] res,
                           input logic endb);
    logic [135:0] f;
    f = {2'b00, res, pat[127:1], endb};
    issue(3'd6, 6'd2);
    for (int k = 135; k >= 0; k--) send_bit(f[k]);
    chk({tag, " R7/R5 status"}, stat(),
        {27'd0, (res == 6'h3F) && endb, 1'b0, !endb, 1'b0, res != 6'h3F});
    chk({tag, " R3 w0"}, w0, f[39:8]);
    chk({tag, " R3 w1"}, w1, f[71:40]);
    chk({tag, " R3 w2"}, w2, f[103:72]);
    chk({tag, " R3 w3"}, w3, {8'h00, f[127:104]});
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 regs", w0 | w1 | w2 | w3, 32'd0);
    chk("R11 flags", {stat()[4:0], busy, active}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R6/R7/R8 sweep over short types, indices, payloads and start delays
    foreach (rtype_list[ti]) ;
    for (int ti = 0; ti < 3; ti++) begin
      logic [2:0] t = (ti == 0) ? 3'd4 : (ti == 1) ? 3'd5 : 3'd7;
      for (int ii = 0; ii < 6; ii++) begin
        logic [5:0] ix = (ii == 0) ? 6'd0 : (ii == 1) ? 6'd1 : (ii == 2) ? 6'd2 :
                         (ii == 3) ? 6'd17 : (ii == 4) ? 6'd40 : 6'd63;
        for (int p = 0; p < 3; p++) begin
          logic [31:0] pay = (32'hA5C3_0F96 ^ ({26'd0, ix} * 32'h0101_0101)) + p * 32'h1234_5677;
          short_case("sweep", t, ix, (t == 3'd7) ? 6'h3F : ix, pay, 7'd0, 1'b1, (ii + p) % 5);
        end
      end
    end

    // R6 CRC fault on checked and unchecked types
    short_case("R6 crc bad r1", 3'd4, 6'd17, 6'd17, 32'hDEAD_BEEF, 7'h04, 1'b1, 2);
    short_case("R6 crc bad r1b", 3'd5, 6'd7, 6'd7, 32'h0000_0001, 7'h40, 1'b1, 0);
    short_case("R6 crc ignored r3", 3'd7, 6'd41, 6'h3F, 32'h80FF_0000, 7'h55, 1'b1, 1);
    // R5 end bit
    short_case("R5 end bad", 3'd4, 6'd3, 6'd3, 32'h1357_9BDF, 7'd0, 1'b0, 0);
    // R7 index faults
    short_case("R7 idx bad r1", 3'd4, 6'd8, 6'd9, 32'hCAFE_F00D, 7'd0, 1'b1, 0);
    short_case("R7 idx bad r3", 3'd7, 6'd41, 6'h3E, 32'h0F0F_0F0F, 7'd0, 1'b1, 0);
    // R4 start bit on the last permitted tick
    short_case("R4 late start", 3'd4, 6'd12, 6'd12, 32'h7777_1111, 7'd0, 1'b1, 63);

    // R3 long frames, R7 reserved field, R6 inner CRC not checked
    for (int s = 1; s <= 3; s++) begin
      logic [31:0] sd = s;
      long_case("R3 long", {sd * 32'h9E37_79B9, sd * 32'h7F4A_7C15 ^ 32'hFFFF_0000,
                            ~sd * 32'h3C6E_F372, sd ^ 32'hDEAD_BEEF}, 6'h3F, 1'b1);
    end
    long_case("R7 long res bad", {4{32'h0123_4567}}, 6'h1F, 1'b1);
    long_case("R5 long end bad", {4{32'h89AB_CDEF}}, 6'h3F, 1'b0);

    // R1 no-response codes
    for (int t = 0; t < 4; t++) begin
      prev = w0;
      issue(3'(t), 6'd5);
      chk("R1 done", stat(), 32'h10);
      chk("R1 idle", {31'd0, active}, 32'd0);
      chk("R1 regs kept", w0, prev);
    end

    // R4 timeout
    issue(3'd4, 6'd1);
    for (int k = 0; k < 63; k++) send_bit(1'b1);
    chk("R4 no early flag", stat(), 32'd0);
    send_bit(1'b1);
    chk("R4 timeout", stat(), 32'h08);
    chk("R4 idle", {31'd0, active}, 32'd0);

    // R9/R10 busy handling
    dat0 = 1'b0;
    issue(3'd5, 6'd6);
    begin
      logic [47:0] f;
      f = {2'b00, 6'd6, 32'h5A5A_A5A5, 8'h00};
      f[7:1] = crc7(f[47:8]);
      f[0] = 1'b1;
      for (int k = 47; k >= 0; k--) send_bit(f[k]);
    end
    chk("R9 done", stat(), 32'h10);
    chk("R9 busy set", {31'd0, busy}, 32'd1);
    for (int k = 0; k < 3; k++) send_bit(1'b1);
    chk("R9 busy held", {31'd0, busy}, 32'd1);
    issue(3'd3, 6'd0);
    chk("R10 start ignored", stat(), 32'd0);
    chk("R10 busy kept", {31'd0, busy}, 32'd1);
    dat0 = 1'b1;
    send_bit(1'b1);
    chk("R9 busy cleared", {31'd0, busy}, 32'd0);

    // R10 start during wait is ignored: timeout still 64 ticks from the first start
    issue(3'd4, 6'd1);
    for (int k = 0; k < 30; k++) send_bit(1'b1);
    issue(3'd3, 6'd0);
    chk("R10 no done while waiting", stat(), 32'd0);
    for (int k = 0; k < 34; k++) send_bit(1'b1);
    chk("R10 original timeout", stat(), 32'h08);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  logic [0:0] rtype_list [1];
endmodule